// File: doc/BRIEF.md
# Johnson Decade Counter with Seven-Segment Decode

This block counts decimal digits 0 to 9 in a five-stage twisted-ring register and drives a seven-segment display straight from that ring state. Counting events are not taken from a separate clock domain. Instead, a count clock and a clock inhibit are each passed through a synchronizer on a fast system clock. The block combines them into one gated level, which is the count clock AND NOT the inhibit, and each rising edge of that level advances the ring by one digit. As a result, the block counts on a rising count clock while the inhibit is low. It also counts on a falling inhibit while the count clock is held high.

The block has three further outputs. A carry output completes one period per ten counts, so it can clock the next decade. Ripple blanking suppresses a leading zero: a decade that shows zero while its blanking input is high goes dark and raises its blanking output for its neighbour. A lamp-test input lights every segment. The block has no data stream, so all of its pins are plain level controls with no handshake.

Top module: `decade_ring_seg`

## Requirements
- R1: A high `rst` clears the ring to digit 0 at once, without waiting for a clock edge, and holds it there while it stays high, whatever the count inputs do; digit 0 shows carry high.
- R2: When `cnt_clk_i` rises while `inh_i` is low, the displayed digit advances by one (9 wraps to 0). The change appears after the third rising `clk` edge, counting the first edge that samples the new input level. Holding the gated level high adds no further counts.
- R3: While `inh_i` is high, transitions on `cnt_clk_i` do not change the count.
- R4: While `cnt_clk_i` is held high, a falling `inh_i` advances the count by one, and a rising `inh_i` does not.
- R5: The ring steps through exactly ten legal five-bit states: it shifts left and feeds the inverted top bit into bit 0. Any pattern outside those ten is replaced by the zero state on the next count event. The display therefore only ever shows a legal digit pattern, all segments, or blank.
- R6: `carry_o` is high for digits 0 to 4 and low for digits 5 to 9, so it rises on the 9-to-0 wrap and has one period per ten counts.
- R7: `seg_o` is active high, with bit 0 = a, bit 1 = b, and so on up to bit 6 = g. Digits 0 to 9 map to hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Digit 6 includes segment a, digit 7 is a+b+c, and digit 9 includes segment d.
- R8: When `rbi_i` is high and the digit is 0, `rbo_o` is high and all segments are low (unless lamp test is on). In every other case `rbo_o` is low.
- R9: A high `lamp_i` drives `seg_o` to 7F, which overrides both blanking and the digit. It does not change `rbo_o` or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst | input | 1 | Active-high asynchronous clear of the whole block |
| cnt_clk_i | input | 1 | Count clock, asynchronous to `clk` |
| inh_i | input | 1 | Clock inhibit; its falling edge counts while `cnt_clk_i` is high |
| rbi_i | input | 1 | Ripple-blanking input from the more significant decade |
| lamp_i | input | 1 | Lamp test, lights all segments |
| seg_o | output | 7 | Segments a..g in bits 0..6, active high |
| carry_o | output | 1 | Carry for the next decade, high for digits 0 to 4 |
| rbo_o | output | 1 | Ripple-blanking output, high when this decade is blanked as zero |

## Verification
The assertions assume that `rst` is high from time zero until the count inputs have settled low. They also assume that `rbi_i` and `lamp_i` only matter as levels, since these two inputs reach the outputs without a register. The stimulus changes every input only at the falling `clk` edge and holds each level for at least one full system cycle, so the synchronizer never sees a metastable sample and the reference model can place each count on an exact edge. The ring's legality and step rules are checked on the internal state, because no port can force an illegal pattern into the ring.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int RING_W  = 5;
  localparam int DIGITS  = 2 * RING_W;
  localparam int SEG_W   = 7;

  typedef logic [RING_W-1:0] ring_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [3:0]        digit_t;

  // A legal twisted-ring word has at most one boundary between ones and zeros.
  function automatic logic ring_legal(input ring_t q);
    int edges;
    edges = 0;
    for (int i = 0; i < RING_W - 1; i++)
      if (q[i] != q[i+1]) edges++;
    return (edges <= 1) && !(edges == 1 && q[0] == 1'b0 && q[RING_W-1] == 1'b0)
           && !(edges == 1 && q[0] == 1'b1 && q[RING_W-1] == 1'b1);
  endfunction

  function automatic digit_t ring_to_digit(input ring_t q);
    int ones;
    ones = 0;
    for (int i = 0; i < RING_W; i++)
      if (q[i]) ones++;
    if (q[0] || ones == 0)
      return digit_t'(ones);
    return digit_t'(DIGITS - ones);
  endfunction

  function automatic seg_t digit_to_seg(input digit_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
        if (rst)
          chain[s] <= '0;
        else if (s == 0)
          chain[s] <= d_i;
        else
          chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/drs_event.sv
module drs_event (
  input  logic clk,
  input  logic rst,
  input  logic cclk_s_i,
  input  logic inh_s_i,
  output logic step_o
);
  logic gated;
  logic gated_q;

  assign gated = cclk_s_i & ~inh_s_i;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      gated_q <= 1'b0;
    else
      gated_q <= gated;
  end

  assign step_o = gated & ~gated_q;
endmodule

// File: rtl/drs_ring.sv
module drs_ring
  import drs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  step_i,
  output ring_t ring_o
);
  ring_t q;
  ring_t q_next;

  always_comb begin
    if (ring_legal(q))
      q_next = {q[RING_W-2:0], ~q[RING_W-1]};
    else
      q_next = '0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      q <= '0;
    else if (step_i)
      q <= q_next;
  end

  assign ring_o = q;
endmodule

// File: rtl/drs_decode.sv
module drs_decode
  import drs_pkg::*;
(
  input  ring_t ring_i,
  input  logic  rbi_i,
  input  logic  lamp_i,
  output seg_t  seg_o,
  output logic  carry_o,
  output logic  rbo_o
);
  digit_t digit;
  logic   blank;

  assign digit   = ring_to_digit(ring_i);
  assign carry_o = ~ring_i[RING_W-1];
  assign blank   = rbi_i && (ring_i == '0);
  assign rbo_o   = blank;

  always_comb begin
    if (lamp_i)
      seg_o = '1;
    else if (blank)
      seg_o = '0;
    else
      seg_o = digit_to_seg(digit);
  end
endmodule

// File: rtl/decade_ring_seg.sv
module decade_ring_seg
  import drs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_clk_i,
  input  logic       inh_i,
  input  logic       rbi_i,
  input  logic       lamp_i,
  output logic [6:0] seg_o,
  output logic       carry_o,
  output logic       rbo_o
);
  logic [1:0] raw_in;
  logic [1:0] synced;
  logic       step;
  ring_t      ring_q;

  assign raw_in = {inh_i, cnt_clk_i};

  drs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (synced)
  );

  drs_event u_event (
    .clk      (clk),
    .rst      (rst),
    .cclk_s_i (synced[0]),
    .inh_s_i  (synced[1]),
    .step_o   (step)
  );

  drs_ring u_ring (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .ring_o (ring_q)
  );

  drs_decode u_decode (
    .ring_i  (ring_q),
    .rbi_i   (rbi_i),
    .lamp_i  (lamp_i),
    .seg_o   (seg_o),
    .carry_o (carry_o),
    .rbo_o   (rbo_o)
  );
endmodule

// File: rtl/decade_ring_seg_chk.sv
module decade_ring_seg_chk (
  input logic       clk,
  input logic       rst,
  input logic       rbi_i,
  input logic       lamp_i,
  input logic [6:0] seg_o,
  input logic       carry_o,
  input logic       rbo_o,
  input logic [4:0] ring_q
);
  // R5
  ring_legal_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ring_q[3:0] ^ ring_q[4:1]) <= 1);

  // R5
  ring_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ring_q) |-> ring_q == {$past(ring_q[3:0]), ~$past(ring_q[4])});

  // R6
  carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_o) |-> ring_q == 5'b00000);

  // R9
  lamp_on_chk: assert property (@(posedge clk) disable iff (rst)
    lamp_i |-> seg_o == 7'h7F);

  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (rbo_o && !lamp_i) |-> seg_o == 7'h00);

  // R8
  rbo_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rbo_o |-> (rbi_i && carry_o && ring_q == 5'b00000));
endmodule

bind decade_ring_seg decade_ring_seg_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rbi_i   (rbi_i),
  .lamp_i  (lamp_i),
  .seg_o   (seg_o),
  .carry_o (carry_o),
  .rbo_o   (rbo_o),
  .ring_q  (ring_q)
);

// File: tb/decade_ring_seg_tb.sv
`timescale 1ns/1ps
module decade_ring_seg_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_clk_i = 1'b0;
  logic       inh_i = 1'b0;
  logic       rbi_i = 1'b0;
  logic       lamp_i = 1'b0;
  logic [6:0] seg_o;
  logic       carry_o;
  logic       rbo_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int model_digit = 0;
  bit gq[$];

  always #2 clk = ~clk;

  decade_ring_seg u_dut (
    .clk       (clk),
    .rst       (rst),
    .cnt_clk_i (cnt_clk_i),
    .inh_i     (inh_i),
    .rbi_i     (rbi_i),
    .lamp_i    (lamp_i),
    .seg_o     (seg_o),
    .carry_o   (carry_o),
    .rbo_o     (rbo_o)
  );

  function automatic logic [6:0] exp_pattern(input int d);
    case (d)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7D;
      7: return 7'h07;
      8: return 7'h7F;
      default: return 7'h6F;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h (digit %0d) at %0t",
               tag, act, exp, model_digit, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    bit blank;
    logic [6:0] es;
    blank = rbi_i && (model_digit == 0);
    if (lamp_i)      es = 7'h7F;
    else if (blank)  es = 7'h00;
    else             es = exp_pattern(model_digit);
    chk(tag, int'(seg_o), int'(es));
    chk("R6", int'(carry_o), (model_digit < 5) ? 1 : 0);
    chk("R8", int'(rbo_o), blank ? 1 : 0);
  endtask

  // One system cycle: drive at the falling edge, compare, then advance the model at the rising edge.
  task automatic step(input string tag, input bit r, input bit cc, input bit ih,
                      input bit rb, input bit lt);
    @(negedge clk);
    rst = r; cnt_clk_i = cc; inh_i = ih; rbi_i = rb; lamp_i = lt;
    if (r) begin
      model_digit = 0;
      gq = '{1'b0, 1'b0, 1'b0};
    end
    #1;
    compare_all(tag);
    @(posedge clk);
    if (!r) begin
      if (gq[gq.size()-2] && !gq[gq.size()-3])
        model_digit = (model_digit + 1) % 10;
      gq.push_back(cc && !ih);
      void'(gq.pop_front());
    end
  endtask

  task automatic run(input string tag, input int n, input bit cc, input bit ih,
                     input bit rb, input bit lt);
    for (int i = 0; i < n; i++) step(tag, 1'b0, cc, ih, rb, lt);
  endtask

  initial begin
    gq = '{1'b0, 1'b0, 1'b0};
    // R1 reset state
    for (int i = 0; i < 4; i++) step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R1", 3, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2 R7 R6 full sweep with wrap, varied pulse widths
    for (int k = 0; k < 12; k++) begin
      run("R2", 1 + (k % 3), 1'b1, 1'b0, 1'b0, 1'b0);
      run("R7", 2 + (k % 4), 1'b0, 1'b0, 1'b0, 1'b0);
    end
    // R2 held-high level gives a single count
    run("R2", 12, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R2", 4, 1'b0, 1'b0, 1'b0, 1'b0);

    // R3 inhibit blocks count-clock edges
    run("R3", 2, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      run("R3", 2, 1'b1, 1'b1, 1'b0, 1'b0);
      run("R3", 2, 1'b0, 1'b1, 1'b0, 1'b0);
    end

    // R4 inhibit as a falling-edge clock with count clock high
    run("R4", 4, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 7; k++) begin
      run("R4", 3, 1'b1, 1'b0, 1'b0, 1'b0);
      run("R4", 3, 1'b1, 1'b1, 1'b0, 1'b0);
    end
    run("R4", 4, 1'b0, 1'b1, 1'b0, 1'b0);
    run("R4", 4, 1'b0, 1'b0, 1'b0, 1'b0);

    // R1 reset while toggling, then R8 blanking at zero
    step("R1", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R1", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R1", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R8", 3, 1'b0, 1'b0, 1'b1, 1'b0);
    // R9 lamp test overrides blanking
    run("R9", 3, 1'b0, 1'b0, 1'b1, 1'b1);
    // R8 nonzero digit is not blanked; R9 lamp over a digit
    for (int k = 0; k < 10; k++) begin
      run("R8", 2, 1'b1, 1'b0, 1'b1, (k % 3) == 0);
      run("R9", 3, 1'b0, 1'b0, 1'b1, (k % 2) == 0);
    end
    // R5 long run: only legal patterns, blank or all-on ever appear
    for (int k = 0; k < 25; k++) begin
      run("R5", 1, 1'b1, (k % 5) == 3, 1'b0, 1'b0);
      run("R5", 2, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    run("R5", 5, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule